// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block walks a table of transfer descriptors held in memory and turns it into a stream of data segments for a separate data mover. Software sets a table base address, split across a low and a high 32-bit input, and selects the descriptor format. It then pulses `start`. The walker fetches each descriptor one 32-bit word at a time through a simple read request and response port. It decodes the flags and the length, and then does one of three things: it hands an address and length segment to the data mover, it skips the descriptor, or it stops.

Two descriptor formats exist. The narrow format is two words: a flags and length word, then a 32-bit segment address. The wide format is three words: the same first two words, then the upper 32 bits of the segment address. The walk ends cleanly on a descriptor that carries the end flag, and `done` pulses. It ends with an `err` pulse on a descriptor that is malformed, on a misaligned segment address, or on a misaligned table base.

Top module: `sgd_walker`

## Requirements
- R1: After reset `busy`, `rd_req_valid`, `seg_valid`, `done` and `err` are all low.
- R2: A `start` whose table base is not 8-byte aligned (base bits [2:0] not zero) produces a one-cycle `err` pulse, issues no memory read and leaves `busy` low.
- R3: Descriptor words are fetched one read at a time from consecutive 32-bit addresses starting at the descriptor address: 2 words per descriptor in narrow mode (`wide_mode`=0) and 3 in wide mode (`wide_mode`=1). A request is held with a stable address until `rd_req_ready` accepts it.
- R4: Word layout: word 0 bits [15:0] are the flags and bits [31:16] the length. Word 1 is segment address bits [31:0]. In wide mode word 2 is address bits [63:32]. In narrow mode the upper address bits are zero.
- R5: Flags decode: bit 0 = valid, bit 1 = end, bits [5:4] = action. Action 2'b10 is a transfer and 2'b00 is a no-op. A valid descriptor with action 2'b01 or 2'b11 ends the walk with `err`.
- R6: A valid transfer descriptor (for example flags 0x21) issues exactly one segment on `seg_addr`/`seg_len`. The segment is held stable with `seg_valid` high until `seg_ready` accepts it.
- R7: A length field of zero yields `seg_len` = 65536. Any other value yields that value.
- R8: A valid no-op descriptor issues no segment, and the walk continues with the next descriptor.
- R9: After the walker finishes a descriptor with the end flag set (a transfer once its segment is accepted, or a no-op such as flags 0x03), `done` pulses for one cycle and the walker returns to idle.
- R10: A fetched descriptor with the valid bit clear (for example flags 0x02) stops the walk with a one-cycle `err` pulse and no further reads.
- R11: A transfer descriptor whose segment address bits [1:0] are not zero produces `err` and no segment.
- R12: Each next descriptor address is the previous one plus 8 in narrow mode and plus 12 in wide mode.
- R13: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk from the table base |
| wide_mode | input | 1 | 1 selects 12-byte descriptors, 0 selects 8-byte descriptors |
| base_lo | input | 32 | Table base address, low word |
| base_hi | input | 32 | Table base address, high word |
| rd_req_valid | output | 1 | Descriptor word read request |
| rd_req_addr | output | ADDR_W | Byte address of the requested word |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_rsp_valid | input | 1 | Read data is valid |
| rd_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered to the data mover |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | 17 | Segment length in bytes (1 to 65536) |
| seg_ready | input | 1 | Data mover accepts the segment |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: walk ended on an end descriptor |
| err | output | 1 | One-cycle pulse: walk aborted on an error |

## Verification
The bench builds the walker with the default ADDR_W of 64. This brings wide-mode descriptors, whose high word reaches address bit 32 and above, fully into reach, along with the 12-byte stepping between them. A scoreboard expects every word address the walker should request and every segment it should emit. Memory-ready and segment-ready backpressure is toggled in some walks to exercise the hold rules. Chains are laid out so that the zero length, skipped no-ops, end-on-no-op, invalid flags, illegal action codes, misaligned segments, a misaligned base and a restart attempt mid-walk each show at the ports.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int SEG_W  = LEN_W + 1;

    localparam logic [1:0] ACT_XFER = 2'b10;
    localparam logic [1:0] ACT_NOP  = 2'b00;

    typedef enum logic [1:0] {W_IDLE, W_FETCH, W_SEG} walk_st_e;
    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_st_e;
endpackage

// File: rtl/sgd_flag_decode.sv
module sgd_flag_decode
    import sgd_pkg::*;
(
    input  logic [3:0]       flags,   // {action[1:0], end, valid}
    input  logic [LEN_W-1:0] len_raw,
    output logic             is_valid,
    output logic             is_end,
    output logic             is_xfer,
    output logic             bad_act,
    output logic [SEG_W-1:0] seg_len
);
    always_comb begin
        is_valid = flags[0];
        is_end   = flags[1];
        is_xfer  = (flags[3:2] == ACT_XFER);
        bad_act  = (flags[3:2] != ACT_XFER) && (flags[3:2] != ACT_NOP);
        // zero encodes the full 64 KiB span
        seg_len  = (len_raw == '0) ? SEG_W'(1) << LEN_W : {1'b0, len_raw};
    end
endmodule

// File: rtl/sgd_fetch.sv
module sgd_fetch
    import sgd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic              wide,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [WORD_W-1:0] rd_rsp_data,
    output logic              desc_valid,
    output logic [3:0]        desc_flags,
    output logic [LEN_W-1:0]  desc_len,
    output logic [ADDR_W-1:0] desc_addr
);
    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] base;
        logic [1:0]        idx;
        logic [3:0]        flags;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] alo;
        logic [WORD_W-1:0] ahi;
        logic              dvalid;
    } fetch_t;

    fetch_t r_q, r_d;
    logic [1:0]  last_idx;
    logic [63:0] full_addr;

    always_comb begin
        last_idx = wide ? 2'd2 : 2'd1;
        r_d = r_q;
        r_d.dvalid = 1'b0;
        unique case (r_q.st)
            F_IDLE: if (go) begin
                r_d.base = go_addr;
                r_d.idx  = '0;
                r_d.st   = F_REQ;
            end
            F_REQ: if (rd_req_ready) r_d.st = F_WAIT;
            F_WAIT: if (rd_rsp_valid) begin
                unique case (r_q.idx)
                    2'd0: begin
                        r_d.flags = {rd_rsp_data[5:4], rd_rsp_data[1:0]};
                        r_d.len   = rd_rsp_data[31:16];
                    end
                    2'd1:    r_d.alo = rd_rsp_data;
                    default: r_d.ahi = rd_rsp_data;
                endcase
                if (r_q.idx == last_idx) begin
                    r_d.dvalid = 1'b1;
                    r_d.st     = F_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 2'd1;
                    r_d.st  = F_REQ;
                end
            end
            default: r_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_valid = (r_q.st == F_REQ);
    assign rd_req_addr  = r_q.base + ADDR_W'({r_q.idx, 2'b00});
    assign full_addr    = {wide ? r_q.ahi : '0, r_q.alo};
    assign desc_valid   = r_q.dvalid;
    assign desc_flags   = r_q.flags;
    assign desc_len     = r_q.len;
    assign desc_addr    = full_addr[ADDR_W-1:0];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)) // R3
        else $error("request dropped or moved before acceptance");
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
    import sgd_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [31:0]       base_lo,
    input  logic [31:0]       base_hi,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [16:0]       seg_len,
    input  logic              seg_ready,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(12);

    typedef struct packed {
        walk_st_e          st;
        logic              wide;
        logic [ADDR_W-1:0] ptr;
        logic              seg_valid;
        logic [ADDR_W-1:0] seg_addr;
        logic [SEG_W-1:0]  seg_len;
        logic              last;
        logic              done;
        logic              err;
    } walk_t;

    walk_t r_q, r_d;

    logic [63:0]       base64;
    logic [ADDR_W-1:0] base, nxt_ptr, go_addr;
    logic              go;
    logic              d_valid;
    logic [3:0]        d_flags;
    logic [LEN_W-1:0]  d_len;
    logic [ADDR_W-1:0] d_addr;
    logic              is_valid, is_end, is_xfer, bad_act;
    logic [SEG_W-1:0]  dec_len;

    assign base64  = {base_hi, base_lo};
    assign base    = base64[ADDR_W-1:0];
    assign nxt_ptr = r_q.ptr + (r_q.wide ? STEP_WIDE : STEP_NARROW);

    sgd_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .go_addr     (go_addr),
        .wide        (r_q.wide),
        .rd_req_valid(rd_req_valid),
        .rd_req_addr (rd_req_addr),
        .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data (rd_rsp_data),
        .desc_valid  (d_valid),
        .desc_flags  (d_flags),
        .desc_len    (d_len),
        .desc_addr   (d_addr)
    );

    sgd_flag_decode u_dec (
        .flags   (d_flags),
        .len_raw (d_len),
        .is_valid(is_valid),
        .is_end  (is_end),
        .is_xfer (is_xfer),
        .bad_act (bad_act),
        .seg_len (dec_len)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        go      = 1'b0;
        go_addr = nxt_ptr;
        unique case (r_q.st)
            W_IDLE: if (start) begin
                if (base[2:0] != 3'b000) begin
                    r_d.err = 1'b1;
                end else begin
                    r_d.ptr  = base;
                    r_d.wide = wide_mode;
                    go       = 1'b1;
                    go_addr  = base;
                    r_d.st   = W_FETCH;
                end
            end
            W_FETCH: if (d_valid) begin
                if (!is_valid || bad_act || (is_xfer && d_addr[1:0] != 2'b00)) begin
                    r_d.err = 1'b1;
                    r_d.st  = W_IDLE;
                end else if (is_xfer) begin
                    r_d.seg_valid = 1'b1;
                    r_d.seg_addr  = d_addr;
                    r_d.seg_len   = dec_len;
                    r_d.last      = is_end;
                    r_d.st        = W_SEG;
                end else if (is_end) begin
                    r_d.done = 1'b1;
                    r_d.st   = W_IDLE;
                end else begin
                    r_d.ptr = nxt_ptr;
                    go      = 1'b1;
                end
            end
            W_SEG: if (seg_ready) begin
                r_d.seg_valid = 1'b0;
                if (r_q.last) begin
                    r_d.done = 1'b1;
                    r_d.st   = W_IDLE;
                end else begin
                    r_d.ptr = nxt_ptr;
                    go      = 1'b1;
                    r_d.st  = W_FETCH;
                end
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign seg_valid = r_q.seg_valid;
    assign seg_addr  = r_q.seg_addr;
    assign seg_len   = r_q.seg_len;
    assign busy      = (r_q.st != W_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)) // R6
        else $error("segment changed before acceptance");
    AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_addr[1:0] == 2'b00) // R11
        else $error("misaligned segment offered");
    AST_SEG_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0) && (seg_len <= 17'h10000)) // R7
        else $error("segment length out of range");
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy) // R9
        else $error("done not a single pulse");
    AST_DONE_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !seg_valid) // R9
        else $error("done while segment pending");
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid) // R10
        else $error("read issued while idle");
endmodule

// File: tb/test_sgd_walker.sv
module test_sgd_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 100000;
    localparam int ADDR_W     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              wide_mode = 1'b0;
    logic [31:0]       base_lo = '0;
    logic [31:0]       base_hi = '0;
    logic              rd_req_valid;
    logic [ADDR_W-1:0] rd_req_addr;
    logic              rd_req_ready = 1'b1;
    logic              rd_rsp_valid = 1'b0;
    logic [31:0]       rd_rsp_data = '0;
    logic              seg_valid;
    logic [ADDR_W-1:0] seg_addr;
    logic [16:0]       seg_len;
    logic              seg_ready = 1'b1;
    logic              busy, done, err;

    sgd_walker #(.ADDR_W(ADDR_W)) i_sgd_walker (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0]       mem [0:1023];
    logic [ADDR_W-1:0] exp_rd [$];
    logic [80:0]       exp_seg [$];
    int  n_chk = 0, n_err = 0, cyc = 0, d_seen = 0, e_seen = 0;
    bit  stall = 1'b0, rsp_pend = 1'b0;
    logic [ADDR_W-1:0] paddr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [80:0] act, input logic [80:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // responder, scoreboard monitor and watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
        rd_rsp_valid = 1'b0;
        if (rsp_pend) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem[paddr[11:2]];
            rsp_pend     = 1'b0;
        end
        rd_req_ready = stall ? ~rd_req_ready : 1'b1;
        if (rd_req_valid && rd_req_ready) begin
            if (exp_rd.size() == 0)
                chk(1'b0, "R3", "unexpected read", 81'(rd_req_addr), 81'h0);
            else begin
                logic [ADDR_W-1:0] e;
                e = exp_rd.pop_front();
                chk(rd_req_addr == e, "R12", "read address", 81'(rd_req_addr), 81'(e));
            end
            rsp_pend = 1'b1;
            paddr    = rd_req_addr;
        end
        seg_ready = stall ? ~seg_ready : 1'b1;
        if (seg_valid && seg_ready) begin
            if (exp_seg.size() == 0)
                chk(1'b0, "R6", "unexpected segment", {seg_addr, seg_len}, 81'h0);
            else begin
                logic [80:0] e;
                e = exp_seg.pop_front();
                chk({seg_addr, seg_len} == e, "R4", "segment addr/len", {seg_addr, seg_len}, e);
            end
        end
        if (done) d_seen++;
        if (err)  e_seen++;
    end

    task automatic put_desc(input int a, input logic [15:0] flg, input logic [15:0] len,
                            input logic [31:0] lo, input logic [31:0] hi, input bit wide);
        mem[a/4]     = {len, flg};
        mem[a/4 + 1] = lo;
        if (wide) mem[a/4 + 2] = hi;
    endtask

    task automatic expect_reads(input int base, input int nwords);
        for (int k = 0; k < nwords; k++) exp_rd.push_back(ADDR_W'(base + 4*k));
    endtask

    task automatic walk(input int base, input bit wide, input bit stl, input int restart_base,
                        input int exp_done, input int exp_err, input string req);
        stall = stl;
        d_seen = 0; e_seen = 0;
        @(negedge clk);
        base_lo = base; wide_mode = wide; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_base >= 0) begin
            repeat (4) @(negedge clk);
            base_lo = restart_base; wide_mode = ~wide; start = 1'b1;  // R13: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        repeat (2) @(negedge clk);
        for (int w = 0; w < 2000 && busy; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        stall = 1'b0;
        chk(d_seen == exp_done, req, "done pulses", 81'(d_seen), 81'(exp_done));
        chk(e_seen == exp_err, req, "err pulses", 81'(e_seen), 81'(exp_err));
        chk(exp_rd.size() == 0, req, "reads outstanding in scoreboard", 81'(exp_rd.size()), 81'h0);
        chk(exp_seg.size() == 0, req, "segments outstanding in scoreboard", 81'(exp_seg.size()), 81'h0);
        exp_rd.delete(); exp_seg.delete();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | i;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !rd_req_valid && !seg_valid && !done && !err, "R1", "reset outputs",
            {busy, rd_req_valid, seg_valid, done, err}, 81'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !rd_req_valid, "R1", "idle after reset", {busy, rd_req_valid}, 81'h0);

        // R8 R7 R9 R12: narrow chain, transfer, no-op skip, zero length with end
        put_desc(32'h100, 16'h0021, 16'h0200, 32'h0000_1000, 0, 0);
        put_desc(32'h108, 16'h0001, 16'h0010, 32'h0000_5000, 0, 0);
        put_desc(32'h110, 16'h0023, 16'h0000, 32'h2000_0004, 0, 0);
        expect_reads(32'h100, 6);
        exp_seg.push_back({64'h1000, 17'h200});
        exp_seg.push_back({64'h2000_0004, 17'h10000});
        walk(32'h100, 0, 0, -1, 1, 0, "R7");

        // R4 R12: wide chain with high address word, under backpressure, ending on no-op
        put_desc(32'h200, 16'h0021, 16'h0040, 32'h0000_0080, 32'h0000_0001, 1);
        put_desc(32'h20C, 16'h0003, 16'h0000, 32'h0000_0777, 32'h0000_0009, 1);
        expect_reads(32'h200, 6);
        exp_seg.push_back({64'h1_0000_0080, 17'h40});
        walk(32'h200, 1, 1, -1, 1, 0, "R4");

        // R10: valid clear stops the walk after the first segment
        put_desc(32'h300, 16'h0021, 16'h0008, 32'h0000_3000, 0, 0);
        put_desc(32'h308, 16'h0002, 16'h0008, 32'h0000_3100, 0, 0);
        expect_reads(32'h300, 4);
        exp_seg.push_back({64'h3000, 17'h8});
        walk(32'h300, 0, 0, -1, 0, 1, "R10");

        // R11: misaligned segment address
        put_desc(32'h340, 16'h0023, 16'h0010, 32'h0000_1002, 0, 0);
        expect_reads(32'h340, 2);
        walk(32'h340, 0, 0, -1, 0, 1, "R11");

        // R5: illegal action code
        put_desc(32'h380, 16'h0013, 16'h0010, 32'h0000_1000, 0, 0);
        expect_reads(32'h380, 2);
        walk(32'h380, 0, 0, -1, 0, 1, "R5");

        // R2: misaligned table base, no reads at all
        walk(32'h304, 0, 0, -1, 0, 1, "R2");

        // R13: restart during a walk is ignored (repeat of the narrow chain)
        expect_reads(32'h100, 6);
        exp_seg.push_back({64'h1000, 17'h200});
        exp_seg.push_back({64'h2000_0004, 17'h10000});
        walk(32'h100, 0, 1, 32'h380, 1, 0, "R13");

        // R6 R3: back-to-back transfer descriptors under backpressure
        put_desc(32'h3C0, 16'h0021, 16'h0004, 32'h0000_0100, 0, 0);
        put_desc(32'h3C8, 16'h0023, 16'hFFFF, 32'h0000_0200, 0, 0);
        expect_reads(32'h3C0, 4);
        exp_seg.push_back({64'h100, 17'h4});
        exp_seg.push_back({64'h200, 17'hFFFF});
        walk(32'h3C0, 0, 1, -1, 1, 0, "R6");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule